// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read data path of a byte-wide non-volatile memory model. While the memory's internal programming cycle runs, it replaces ordinary read data with two end-of-write indicators, so a host that only has the read bus can tell when a write has finished. The most significant data bit returns the inverse of the most significant bit of the byte that was written last. The bit below it flips from one read access to the next. Once programming has finished, the array contents come through unchanged on every bit.

The memory's write logic gives a one-cycle commit pulse when a page load closes, together with the last address and data of that load. The block keeps both. The array supplies its read word for the current read address. The three active-low strobes decide when the read bus is driven. A read access opens when chip select and output enable are both low while write enable is high. It closes when that condition goes away, whether chip select rises, output enable rises or both rise. A parameter chooses whether the inverted bit appears at every address or only at the address that was written last.

Top module: `eeprom_wr_status`

## Requirements
- R1: `rd_oe` is 1 exactly when `cs_n`=0, `oe_n`=0 and `we_n`=1. While `rd_oe` is 0, `rd_data` is all zeros.
- R2: While `prog_busy`=0, a read returns `array_rdata` unchanged on every bit.
- R3: A cycle with `wr_commit`=1 captures `wr_addr` and `wr_data` at that clock edge. Changes on `wr_addr` and `wr_data` without `wr_commit` leave the captured values as they were.
- R4: While `prog_busy`=1 and the poll condition holds, bit DATA_W-1 of `rd_data` is the inverse of bit DATA_W-1 of the captured byte. With POLL_MODE=POLL_ANY_ADDR the poll condition always holds.
- R5: While `prog_busy`=1, bits DATA_W-3 down to 0 of `rd_data` equal the same bits of `array_rdata`.
- R6: While `prog_busy`=1, bit DATA_W-2 of `rd_data` shows an internal toggle state. That state inverts at the first clock edge after a read access closes while `prog_busy`=1, no matter which strobe closed the access. Two successive busy reads therefore show opposite values.
- R7: The toggle bit stays constant for the whole of one read access. A read access that closes while `prog_busy`=0 leaves the toggle state unchanged.
- R8: After reset the toggle state is TOGGLE_INIT (default 0), and the captured address and data are zero.
- R9: With POLL_MODE=POLL_MATCH_ADDR, the poll condition of R4 holds only when `rd_addr` equals the captured address. At any other address during busy, bit DATA_W-1 comes from `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_busy | input | 1 | Internal programming cycle in progress |
| wr_commit | input | 1 | One-cycle pulse when a page load closes |
| wr_addr | input | ADDR_W | Address of the last byte of the closing load |
| wr_data | input | DATA_W | Data of the last byte of the closing load |
| rd_addr | input | ADDR_W | Current read address |
| array_rdata | input | DATA_W | Array contents at `rd_addr` |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_data | output | DATA_W | Read bus value |
| rd_oe | output | 1 | Read bus drive enable |

## Verification
The bench sweeps every strobe combination to catch a bus that is driven during a write strobe, and a bus that leaks data while it is not driven. It runs 256 commit-then-poll rounds so that every value of the inverted bit and of the pass-through bits is checked. These rounds alternate between closing the access with output enable and closing it with chip select. A toggle that advanced on only one strobe would then fall out of step within two reads. Each read is sampled twice, and idle reads are placed between busy ones, so a toggle that moved during an access or on an idle read would show up as a phase error at the next busy read. A second instance in address-match mode is read at the captured address and at a neighbouring address in turn. This exposes a poll bit that ignores the address comparison.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

   typedef enum logic [0:0] {
      POLL_ANY_ADDR   = 1'b0,
      POLL_MATCH_ADDR = 1'b1
   } poll_mode_e;

   typedef struct packed {
      logic active;
      logic closed;
   } acc_evt_t;

endpackage

// File: rtl/wsr_access_detect.sv
module wsr_access_detect (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   output wsr_pkg::acc_evt_t evt
);
   logic active_now;
   logic active_prev;

   assign active_now = ~cs_n & ~oe_n & we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_prev <= 1'b0;
      else        active_prev <= active_now;
   end

   always_comb begin
      evt.active = active_now;
      evt.closed = active_prev & ~active_now;
   end
endmodule

// File: rtl/wsr_last_write.sv
module wsr_last_write #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0] held_addr,
   output logic [DATA_W-1:0] held_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_addr <= '0;
         held_data <= '0;
      end else if (commit) begin
         held_addr <= addr_in;
         held_data <= data_in;
      end
   end
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle #(
   parameter logic TOGGLE_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic closed,
   output logic tog
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tog <= TOGGLE_INIT;
      else if (busy && closed) tog <= ~tog;
   end
endmodule

// File: rtl/wsr_out_mux.sv
module wsr_out_mux #(
   parameter int                  ADDR_W    = 13,
   parameter int                  DATA_W    = 8,
   parameter wsr_pkg::poll_mode_e POLL_MODE = wsr_pkg::POLL_ANY_ADDR
) (
   input  logic              busy,
   input  logic              active,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] held_addr,
   input  logic [DATA_W-1:0] held_data,
   input  logic [DATA_W-1:0] array_rdata,
   input  logic              tog,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);
   localparam int POLL_BIT = DATA_W - 1;
   localparam int TOG_BIT  = DATA_W - 2;
   localparam logic ANY    = (POLL_MODE == wsr_pkg::POLL_ANY_ADDR);

   logic              poll_hit;
   logic [DATA_W-1:0] word;

   assign poll_hit = ANY | (rd_addr == held_addr);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == POLL_BIT) begin : g_poll
         assign word[b] = (busy && poll_hit) ? ~held_data[b] : array_rdata[b];
      end else if (b == TOG_BIT) begin : g_tog
         assign word[b] = busy ? tog : array_rdata[b];
      end else begin : g_pass
         assign word[b] = array_rdata[b];
      end
   end

   assign rd_oe   = active;
   assign rd_data = active ? word : '0;
endmodule

// File: rtl/eeprom_wr_status.sv
module eeprom_wr_status #(
   parameter int                  ADDR_W      = 13,
   parameter int                  DATA_W      = 8,
   parameter wsr_pkg::poll_mode_e POLL_MODE   = wsr_pkg::POLL_ANY_ADDR,
   parameter logic                TOGGLE_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_busy,
   input  logic              wr_commit,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] array_rdata,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);
   if (DATA_W < 3) begin : g_bad_data_w
      $error("eeprom_wr_status: DATA_W must be at least 3");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("eeprom_wr_status: ADDR_W must be at least 1");
   end

   wsr_pkg::acc_evt_t evt;
   logic [ADDR_W-1:0] held_addr;
   logic [DATA_W-1:0] held_data;
   logic              tog_q;

   wsr_access_detect u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .oe_n  (oe_n),
      .we_n  (we_n),
      .evt   (evt)
   );

   wsr_last_write #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_last (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (wr_commit),
      .addr_in   (wr_addr),
      .data_in   (wr_data),
      .held_addr (held_addr),
      .held_data (held_data)
   );

   wsr_toggle #(.TOGGLE_INIT(TOGGLE_INIT)) u_tog (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy   (prog_busy),
      .closed (evt.closed),
      .tog    (tog_q)
   );

   wsr_out_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_MODE(POLL_MODE)) u_mux (
      .busy        (prog_busy),
      .active      (evt.active),
      .rd_addr     (rd_addr),
      .held_addr   (held_addr),
      .held_data   (held_data),
      .array_rdata (array_rdata),
      .tog         (tog_q),
      .rd_data     (rd_data),
      .rd_oe       (rd_oe)
   );
endmodule

// File: rtl/eeprom_wr_status_chk.sv
module eeprom_wr_status_chk #(
   parameter int                  ADDR_W    = 13,
   parameter int                  DATA_W    = 8,
   parameter wsr_pkg::poll_mode_e POLL_MODE = wsr_pkg::POLL_ANY_ADDR
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_busy,
   input logic              wr_commit,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] array_rdata,
   input logic              cs_n,
   input logic              we_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_oe,
   input logic [ADDR_W-1:0] held_addr,
   input logic [DATA_W-1:0] held_data,
   input logic              tog_q
);
   localparam int   PB  = DATA_W - 1;
   localparam int   TB  = DATA_W - 2;
   localparam logic ANY = (POLL_MODE == wsr_pkg::POLL_ANY_ADDR);

   assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> rd_data == '0);
   assert_no_drive_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> (we_n && !cs_n));
   assert_idle_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_busy && rd_oe) |-> rd_data == array_rdata);
   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |=> held_data == $past(wr_data));
   assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && rd_oe && (ANY || rd_addr == held_addr)) |-> rd_data[PB] != held_data[PB]);
   assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && rd_oe) |-> rd_data[TB-1:0] == array_rdata[TB-1:0]);
   assert_tog_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_oe && $past(rd_oe) && prog_busy) |=> tog_q != $past(tog_q));
   assert_tog_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && $past(prog_busy) && rd_oe && $past(rd_oe)) |-> $stable(rd_data[TB]));
endmodule

bind eeprom_wr_status eeprom_wr_status_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_MODE(POLL_MODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .wr_commit(wr_commit),
   .wr_data(wr_data), .rd_addr(rd_addr), .array_rdata(array_rdata),
   .cs_n(cs_n), .we_n(we_n), .rd_data(rd_data), .rd_oe(rd_oe),
   .held_addr(held_addr), .held_data(held_data), .tog_q(tog_q)
);

// File: tb/test_eeprom_wr_status.sv
module test_eeprom_wr_status;
   localparam int AW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prog_busy = 1'b0;
   logic          wr_commit = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    array_rdata = '0;
   logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [7:0]    rd_data, rd_data_m;
   logic          rd_oe, rd_oe_m;

   int  n_run = 0, n_fail = 0, cyc = 0;
   bit  done = 0;
   logic tog_exp = 1'b0;

   always #4 clk = ~clk;

   eeprom_wr_status #(.ADDR_W(AW), .DATA_W(8)) i_eeprom_wr_status (
      .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .wr_commit(wr_commit),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .array_rdata(array_rdata), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .rd_data(rd_data), .rd_oe(rd_oe));

   eeprom_wr_status #(.ADDR_W(AW), .DATA_W(8), .POLL_MODE(wsr_pkg::POLL_MATCH_ADDR))
   i_eeprom_wr_status_match (
      .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .wr_commit(wr_commit),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .array_rdata(array_rdata), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .rd_data(rd_data_m), .rd_oe(rd_oe_m));

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic commit(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); wr_commit = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_commit = 1'b0;
   endtask

   // read access: sample twice, close by oe_n or cs_n, advance model toggle
   task automatic do_read(input logic [7:0] exp, input logic [7:0] exp_m,
                          input bit close_cs, input string req);
      @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; #1;
      check(req, {rd_oe, rd_data}, {1'b1, exp});
      check(req, {rd_oe_m, rd_data_m}, {1'b1, exp_m});
      @(negedge clk); #1;
      check({req, " R7 steady"}, {rd_oe, rd_data}, {1'b1, exp});
      @(negedge clk);
      if (close_cs) cs_n = 1'b1; else oe_n = 1'b1;
      @(negedge clk); cs_n = 1'b1; oe_n = 1'b1;
      if (prog_busy) tog_exp = ~tog_exp;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected done", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state seen through a busy read at the captured address 0
      @(negedge clk); prog_busy = 1'b1; array_rdata = 8'h00; rd_addr = '0;
      do_read(8'h80, 8'h80, 1'b0, "R8 reset");
      prog_busy = 1'b0;

      // R1: all strobe combinations, idle
      array_rdata = 8'hC3;
      for (int c = 0; c < 8; c++) begin
         @(negedge clk); cs_n = c[2]; oe_n = c[1]; we_n = c[0]; #1;
         if (c == 1) check("R1 drive", {rd_oe, rd_data}, {1'b1, 8'hC3});
         else        check("R1 float", {rd_oe, rd_data}, 9'h000);
      end
      @(negedge clk); cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;

      // R2: idle pass-through sweep
      for (int v = 0; v < 256; v++) begin
         @(negedge clk); array_rdata = v[7:0]; cs_n = 1'b0; oe_n = 1'b0; #1;
         check("R2 idle", {rd_oe, rd_data}, {1'b1, v[7:0]});
      end
      @(negedge clk); cs_n = 1'b1; oe_n = 1'b1;

      // R4 R5 R6 R7 R9 sweep of commit, busy poll, idle read
      for (int i = 0; i < 256; i++) begin
         logic [7:0]    d, arr, e, em;
         logic [AW-1:0] a;
         d   = 8'(i * 37 + 11);
         a   = AW'(i * 97);
         arr = 8'(i) ^ 8'h5A;
         commit(a, d);
         prog_busy = 1'b1; array_rdata = arr;
         rd_addr = (i % 2 == 1) ? (a ^ AW'(1)) : a;
         e  = {~d[7], tog_exp, arr[5:0]};
         em = {(rd_addr == a) ? ~d[7] : arr[7], tog_exp, arr[5:0]};
         do_read(e, em, (i % 2 == 1), "R4 R5 R6 R9 busy");
         prog_busy = 1'b0;
         do_read(arr, arr, (i % 4 == 0), "R2 R7 idle");
      end

      // R3: data change without commit is ignored
      commit(13'h0123, 8'h00);
      @(negedge clk); wr_addr = 13'h0456; wr_data = 8'hFF;
      prog_busy = 1'b1; array_rdata = 8'h00; rd_addr = 13'h0123;
      do_read({1'b1, tog_exp, 6'h00}, {1'b1, tog_exp, 6'h00}, 1'b0, "R3 no commit");
      // R6: back-to-back busy reads alternate
      do_read({1'b1, tog_exp, 6'h00}, {1'b1, tog_exp, 6'h00}, 1'b1, "R6 alternate");
      do_read({1'b1, tog_exp, 6'h00}, {1'b1, tog_exp, 6'h00}, 1'b0, "R6 alternate");
      prog_busy = 1'b0;

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule